// File: doc/BRIEF.md
# PCI Bus Performance Event Monitor

This block observes the shared-bus control lines of a PCI segment (FRAME#, IRDY#, TRDY#) together with the request and grant lines of a small set of bus agents. It sorts every bus clock into one of three classes: idle, overhead or data transfer. It also follows which agent currently owns the bus. Out of these observations it produces per-clock duration events and grant events, and it accumulates them in saturating counters that software or a debug path reads by index.

One agent is local: it is agent 0 and is wired to `loc_req_n`/`loc_gnt_n`. The other agents are external masters, and external master `i` is agent `i+1`. For each agent the monitor counts acquisition clocks (the request is pending and the agent does not own the bus), ownership clocks and grants. Dividing the acquisition count by the grant count outside the block gives the average acquisition latency. All counting happens only while `mon_en` is high. `cnt_clr` zeroes every counter.

Top module: `pci_perf_monitor`

## Requirements
- R1: Counters change only on clocks where `mon_en` is high. While `mon_en` is low, every counter holds its value.
- R2: Counter index 0 (idle) increments on each clock where FRAME# and IRDY# are both high.
- R3: Counter index 1 (busy) increments on each clock where IRDY# and TRDY# are both low, whichever agent drives the transfer.
- R4: A clock where FRAME# or IRDY# is low but IRDY# and TRDY# are not both low is an overhead clock. It increments neither the idle counter nor the busy counter.
- R5: An agent becomes owner on the clock where FRAME# or IRDY# first goes low after a clock with both high, provided its GNT# was low on that previous clock. If several grants were low, the lowest-numbered agent wins. Ownership lasts until a clock with FRAME# and IRDY# both high. The agent's ownership counter increments on every clock it owns the bus.
- R6: An agent's acquisition counter increments on each clock where its REQ# is low and it is not the owner, whether the bus is idle or another agent owns it.
- R7: An agent's grant counter increments once for each high-to-low transition of its GNT#. A grant held low for several clocks counts once.
- R8: Counters saturate at all ones and never wrap.
- R9: `cnt_clr` high at a clock edge zeroes all counters at that edge, and it takes priority over any increment in the same clock.
- R10: `rd_data` returns, combinationally, the counter selected by `rd_idx`. Index 0 is idle, 1 is busy, 2+3a is acquisition, 3+3a is ownership and 4+3a is grants for agent a. Agent 0 is local and external master i is agent i+1. Any index beyond the last counter reads as zero.
- R11: After reset every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitored bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_en | input | 1 | Counting enable |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| trdy_n | input | 1 | Bus TRDY#, active low |
| loc_req_n | input | 1 | Local agent request, active low |
| loc_gnt_n | input | 1 | Local agent grant, active low |
| ext_req_n | input | NUM_EXT | External master requests, active low |
| ext_gnt_n | input | NUM_EXT | External master grants, active low |
| rd_idx | input | IDX_W | Counter select |
| rd_data | output | CNT_W | Selected counter value |

## Verification
Two conditions are the hardest to reach from the ports. The first is an agent that keeps requesting while a different agent owns the bus. The second is the hand-off of ownership at the first FRAME# of a transaction, which depends on the grant seen one clock earlier. A directed transaction drives request, then grant, then address phase, wait states and data phases in that order, while a second agent keeps its request low throughout, and the resulting counts are compared with literal values. A long pseudo-random run then drives random control levels and one-hot grants, with random enable and clear. A stimulus-level model built from the requirements predicts every counter, including saturation on the narrow counters the bench configures.

// File: rtl/pcimon_pkg.sv
// Package: shared counter map for the PCI performance monitor.
// Assumes a fixed layout of two bus-wide counters followed by three counters per agent.
package pcimon_pkg;

    localparam int IDX_IDLE  = 0;
    localparam int IDX_BUSY  = 1;
    localparam int BUS_CNTS  = 2;
    localparam int PER_AGENT = 3;
    localparam int OFS_ACQ   = 0;
    localparam int OFS_OWN   = 1;
    localparam int OFS_GNT   = 2;

    // Counter index of a given per-agent event.
    function automatic int agent_cnt_idx(input int agent, input int ofs);
        return BUS_CNTS + PER_AGENT * agent + ofs;
    endfunction

endpackage

// File: rtl/pcimon_bus_classifier.sv
// Module: pcimon_bus_classifier
// Classifies each bus clock as idle, overhead or data, and tracks which agent owns the bus.
// Assumes a master starts its transaction on the clock after it saw its grant and an idle bus.
// When several grants were low, the lowest index is taken as owner.
module pcimon_bus_classifier #(
    parameter int NUM_AGENTS = 4,
    parameter int AGT_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_n,
    input  logic                  irdy_n,
    input  logic                  trdy_n,
    input  logic [NUM_AGENTS-1:0] gnt_n,
    output logic                  idle_evt,
    output logic                  data_evt,
    output logic                  own_vld,
    output logic [AGT_W-1:0]      own_idx
);

    logic                  bus_active;
    logic                  txn_start;
    logic                  prev_active_q;
    logic [NUM_AGENTS-1:0] gnt_prev_q;
    logic                  own_vld_q;
    logic [AGT_W-1:0]      own_idx_q;
    logic                  pend_any;
    logic [AGT_W-1:0]      pend_idx;

    assign bus_active = !frame_n || !irdy_n;
    assign txn_start  = bus_active && !prev_active_q;
    assign idle_evt   = !bus_active;
    assign data_evt   = !irdy_n && !trdy_n;

    // Purpose: pick the lowest-numbered agent whose grant was low on the previous clock.
    always_comb begin
        pend_any = 1'b0;
        pend_idx = '0;
        for (int a = NUM_AGENTS - 1; a >= 0; a--) begin
            if (!gnt_prev_q[a]) begin
                pend_any = 1'b1;
                pend_idx = AGT_W'(a);
            end
        end
    end

    // Purpose: the owner is chosen at a transaction start and kept while the bus stays active.
    always_comb begin
        own_vld = bus_active && (txn_start ? pend_any : own_vld_q);
        own_idx = txn_start ? pend_idx : own_idx_q;
    end

    // Purpose: remember last clock's bus activity and grants, and latch the owner at a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_active_q <= 1'b0;
            gnt_prev_q    <= '1;
            own_vld_q     <= 1'b0;
            own_idx_q     <= '0;
        end else begin
            prev_active_q <= bus_active;
            gnt_prev_q    <= gnt_n;
            if (txn_start) begin
                own_vld_q <= pend_any;
                own_idx_q <= pend_idx;
            end
        end
    end

endmodule

// File: rtl/pcimon_agent_events.sv
// Module: pcimon_agent_events
// Produces the acquisition, ownership and grant events of every agent.
// Assumes the owner indication from the classifier is valid on the current clock.
module pcimon_agent_events #(
    parameter int NUM_AGENTS = 4,
    parameter int AGT_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_AGENTS-1:0] req_n,
    input  logic [NUM_AGENTS-1:0] gnt_n,
    input  logic                  own_vld,
    input  logic [AGT_W-1:0]      own_idx,
    output logic [NUM_AGENTS-1:0] acq_evt,
    output logic [NUM_AGENTS-1:0] own_evt,
    output logic [NUM_AGENTS-1:0] grant_evt
);

    logic [NUM_AGENTS-1:0] gnt_last_q;

    // Purpose: hold each grant line's previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_last_q <= '1;
        end else begin
            gnt_last_q <= gnt_n;
        end
    end

    for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_agent
        // Ownership: this agent is the current owner.
        assign own_evt[a]   = own_vld && (own_idx == AGT_W'(a));
        // Acquisition: request pending without ownership.
        assign acq_evt[a]   = !req_n[a] && !own_evt[a];
        // Grant: high-to-low edge of the grant line.
        assign grant_evt[a] = gnt_last_q[a] && !gnt_n[a];
    end

endmodule

// File: rtl/pcimon_sat_counter.sv
// Module: pcimon_sat_counter
// A single event counter that saturates at all ones, with synchronous clear taking priority.
// Assumes the event input is valid for the current clock.
module pcimon_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] MAX_VAL = '1;

    // Purpose: count enabled events, stop at the maximum, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (en && inc && (count != MAX_VAL)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pci_perf_monitor.sv
// Module: pci_perf_monitor (top)
// PCI bus performance event monitor. It reports bus idle and busy cycles, and per-agent
// acquisition, ownership and grant counts, through an indexed read port.
// Assumes agent 0 is the local agent and external master i is agent i+1.
module pci_perf_monitor
    import pcimon_pkg::*;
#(
    parameter  int NUM_EXT    = 3,
    parameter  int CNT_W      = 32,
    localparam int NUM_AGENTS = NUM_EXT + 1,
    localparam int NUM_CNT    = BUS_CNTS + PER_AGENT * NUM_AGENTS,
    localparam int IDX_W      = $clog2(NUM_CNT + 1),
    localparam int AGT_W      = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mon_en,
    input  logic               cnt_clr,
    input  logic               frame_n,
    input  logic               irdy_n,
    input  logic               trdy_n,
    input  logic               loc_req_n,
    input  logic               loc_gnt_n,
    input  logic [NUM_EXT-1:0] ext_req_n,
    input  logic [NUM_EXT-1:0] ext_gnt_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CNT_W-1:0]   rd_data
);

    logic [NUM_AGENTS-1:0] agt_req_n;
    logic [NUM_AGENTS-1:0] agt_gnt_n;
    logic                  idle_evt;
    logic                  data_evt;
    logic                  own_vld;
    logic [AGT_W-1:0]      own_idx;
    logic [NUM_AGENTS-1:0] acq_evt;
    logic [NUM_AGENTS-1:0] own_evt;
    logic [NUM_AGENTS-1:0] grant_evt;
    logic [NUM_CNT-1:0]    cnt_inc;
    logic [CNT_W-1:0]      cnt [NUM_CNT];

    assign agt_req_n = {ext_req_n, loc_req_n};
    assign agt_gnt_n = {ext_gnt_n, loc_gnt_n};

    pcimon_bus_classifier #(
        .NUM_AGENTS (NUM_AGENTS),
        .AGT_W      (AGT_W)
    ) u_classifier (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .trdy_n   (trdy_n),
        .gnt_n    (agt_gnt_n),
        .idle_evt (idle_evt),
        .data_evt (data_evt),
        .own_vld  (own_vld),
        .own_idx  (own_idx)
    );

    pcimon_agent_events #(
        .NUM_AGENTS (NUM_AGENTS),
        .AGT_W      (AGT_W)
    ) u_agents (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (agt_req_n),
        .gnt_n     (agt_gnt_n),
        .own_vld   (own_vld),
        .own_idx   (own_idx),
        .acq_evt   (acq_evt),
        .own_evt   (own_evt),
        .grant_evt (grant_evt)
    );

    assign cnt_inc[IDX_IDLE] = idle_evt;
    assign cnt_inc[IDX_BUSY] = data_evt;

    for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_map
        assign cnt_inc[agent_cnt_idx(a, OFS_ACQ)] = acq_evt[a];
        assign cnt_inc[agent_cnt_idx(a, OFS_OWN)] = own_evt[a];
        assign cnt_inc[agent_cnt_idx(a, OFS_GNT)] = grant_evt[a];
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        pcimon_sat_counter #(
            .W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (mon_en),
            .clr   (cnt_clr),
            .inc   (cnt_inc[k]),
            .count (cnt[k])
        );
    end

    // Purpose: indexed read, returning zero beyond the last counter.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (int'(rd_idx) == k) begin
                rd_data = cnt[k];
            end
        end
    end

endmodule

// File: rtl/pcimon_checker.sv
// Module: pcimon_checker
// Temporal checks on the monitor, bound into the top module.
module pcimon_checker #(
    parameter int NUM_AGENTS = 4,
    parameter int CNT_W      = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mon_en,
    input logic                  cnt_clr,
    input logic                  frame_n,
    input logic                  irdy_n,
    input logic                  trdy_n,
    input logic [NUM_AGENTS-1:0] own_evt,
    input logic [NUM_AGENTS-1:0] grant_evt,
    input logic [CNT_W-1:0]      idle_cnt,
    input logic [CNT_W-1:0]      busy_cnt
);

    localparam logic [CNT_W-1:0] MAX_VAL = '1;

    a_r1_frozen_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en && !cnt_clr) |=> ($stable(idle_cnt) && $stable(busy_cnt)));

    a_r2_idle_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && irdy_n && mon_en && !cnt_clr && idle_cnt != MAX_VAL)
        |=> (idle_cnt == $past(idle_cnt) + 1'b1));

    a_r4_overhead_uncounted: assert property (@(posedge clk) disable iff (!rst_n)
        ((!frame_n || !irdy_n) && !(!irdy_n && !trdy_n) && !cnt_clr)
        |=> ($stable(idle_cnt) && $stable(busy_cnt)));

    a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(own_evt));

    a_r7_grant_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_evt != '0) |=> ((grant_evt & $past(grant_evt)) == '0));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt == MAX_VAL && !cnt_clr) |=> (idle_cnt == MAX_VAL));

    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (idle_cnt == '0 && busy_cnt == '0));

endmodule

bind pci_perf_monitor pcimon_checker #(
    .NUM_AGENTS (NUM_AGENTS),
    .CNT_W      (CNT_W)
) u_pcimon_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_en    (mon_en),
    .cnt_clr   (cnt_clr),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .trdy_n    (trdy_n),
    .own_evt   (own_evt),
    .grant_evt (grant_evt),
    .idle_cnt  (cnt[0]),
    .busy_cnt  (cnt[1])
);

// File: tb/test_pci_perf_monitor.sv
// Bench for pci_perf_monitor: directed transactions with literal expectations, then a
// pseudo-random run compared against a stimulus-level model of the requirements.
module test_pci_perf_monitor;

    localparam int CLK_PERIOD = 100;
    localparam int NUM_EXT    = 3;
    localparam int NAG        = NUM_EXT + 1;
    localparam int CW         = 6;
    localparam int NCNT       = 2 + 3 * NAG;
    localparam int IW         = 4;
    localparam int CMAX       = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mon_en = 1'b0;
    logic          cnt_clr = 1'b0;
    logic          frame_n = 1'b1;
    logic          irdy_n = 1'b1;
    logic          trdy_n = 1'b1;
    logic [NAG-1:0] req_n = '1;
    logic [NAG-1:0] gnt_n = '1;
    logic [IW-1:0] rd_idx = '0;
    logic [CW-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    int exp_c [NCNT];
    bit m_prev_active;
    logic [NAG-1:0] m_prev_gnt;
    bit m_own_vld;
    int m_own_idx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pci_perf_monitor #(
        .NUM_EXT (NUM_EXT),
        .CNT_W   (CW)
    ) i_pci_perf_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_en    (mon_en),
        .cnt_clr   (cnt_clr),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .trdy_n    (trdy_n),
        .loc_req_n (req_n[0]),
        .loc_gnt_n (gnt_n[0]),
        .ext_req_n (req_n[NAG-1:1]),
        .ext_gnt_n (gnt_n[NAG-1:1]),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

    function automatic void model_reset();
        for (int k = 0; k < NCNT; k++) exp_c[k] = 0;
        m_prev_active = 1'b0;
        m_prev_gnt    = '1;
        m_own_vld     = 1'b0;
        m_own_idx     = 0;
    endfunction

    function automatic void bump(input int k);
        if (exp_c[k] < CMAX) exp_c[k] = exp_c[k] + 1;
    endfunction

    // Predicts the counters from the requirements for the inputs of this clock.
    function automatic void model_step();
        bit active;
        bit data;
        bit own;
        active = !frame_n || !irdy_n;
        data   = !irdy_n && !trdy_n;
        if (active && !m_prev_active) begin
            m_own_vld = 1'b0;
            for (int a = NAG - 1; a >= 0; a--) begin
                if (!m_prev_gnt[a]) begin
                    m_own_vld = 1'b1;
                    m_own_idx = a;
                end
            end
        end
        if (cnt_clr) begin
            for (int k = 0; k < NCNT; k++) exp_c[k] = 0;
        end else if (mon_en) begin
            if (!active) bump(0);
            if (data) bump(1);
            for (int a = 0; a < NAG; a++) begin
                own = active && m_own_vld && (m_own_idx == a);
                if (own) bump(3 + 3 * a);
                if (!req_n[a] && !own) bump(2 + 3 * a);
                if (m_prev_gnt[a] && !gnt_n[a]) bump(4 + 3 * a);
            end
        end
        m_prev_active = active;
        m_prev_gnt    = gnt_n;
    endfunction

    function automatic string tag_of(input int k);
        if (k == 0) return "R2";
        if (k == 1) return "R3";
        case ((k - 2) % 3)
            0: return "R6";
            1: return "R5";
            default: return "R7";
        endcase
    endfunction

    // One bus clock: inputs applied at the falling edge, model follows the rising edge.
    task automatic cyc(input logic f, input logic i, input logic t,
                       input logic [NAG-1:0] rq, input logic [NAG-1:0] gn);
        frame_n = f;
        irdy_n  = i;
        trdy_n  = t;
        req_n   = rq;
        gnt_n   = gn;
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int idx, input int exp);
        rd_idx = IW'(idx);
        #1;
        n_chk++;
        if (rd_data !== CW'(exp)) begin
            n_fail++;
            $display("FAIL %s idx=%0d actual=%0d expected=%0d", tag, idx, rd_data, exp);
        end
    endtask

    task automatic check_all();
        for (int k = 0; k < NCNT; k++) check(tag_of(k), k, exp_c[k]);
    endtask

    task automatic clear_cycle();
        cnt_clr = 1'b1;
        cyc(1'b1, 1'b1, 1'b1, '1, '1);
        cnt_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rnd;
        logic [NAG-1:0] gn;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state, read before any enabled clock
        for (int k = 0; k < NCNT; k++) check("R11", k, 0);

        // R2: ten quiet clocks
        mon_en = 1'b1;
        repeat (10) cyc(1'b1, 1'b1, 1'b1, '1, '1);
        check("R2", 0, 10);
        check("R3", 1, 0);
        check_all();

        // R1: disabled while data moves, nothing changes
        mon_en = 1'b0;
        repeat (5) cyc(1'b0, 1'b0, 1'b0, 4'b0000, '1);
        cyc(1'b1, 1'b1, 1'b1, '1, '1);
        check("R1", 0, 10);
        check("R1", 1, 0);
        check("R1", 2, 0);
        mon_en = 1'b1;

        // R4 R5 R6 R7: agent 2 transaction with agent 0 requesting meanwhile
        clear_cycle();
        cyc(1'b1, 1'b1, 1'b1, 4'b1011, 4'b1111);
        cyc(1'b1, 1'b1, 1'b1, 4'b1011, 4'b1011);
        cyc(1'b0, 1'b1, 1'b1, 4'b1110, 4'b1011);
        cyc(1'b0, 1'b0, 1'b1, 4'b1110, 4'b1111);
        cyc(1'b0, 1'b0, 1'b0, 4'b1110, 4'b1111);
        cyc(1'b1, 1'b0, 1'b0, 4'b1110, 4'b1111);
        cyc(1'b1, 1'b1, 1'b1, 4'b1111, 4'b1111);
        check("R4", 0, 3);
        check("R4", 1, 2);
        check("R6", 8, 2);
        check("R5", 9, 4);
        check("R7", 10, 1);
        check("R6", 2, 4);
        check("R5", 3, 0);
        check("R7", 4, 0);
        check_all();

        // R7: grant held low counts once, a fresh edge counts again
        clear_cycle();
        repeat (5) cyc(1'b1, 1'b1, 1'b1, '1, 4'b1101);
        cyc(1'b1, 1'b1, 1'b1, '1, '1);
        repeat (2) cyc(1'b1, 1'b1, 1'b1, '1, 4'b1101);
        check("R7", 7, 2);
        check("R5", 6, 0);

        // R8: saturation; R9: clear beats a same-clock increment
        clear_cycle();
        repeat (70) cyc(1'b1, 1'b1, 1'b1, '1, '1);
        check("R8", 0, CMAX);
        clear_cycle();
        check("R9", 0, 0);
        cyc(1'b1, 1'b1, 1'b1, '1, '1);
        check("R9", 0, 1);

        // R10: indices past the last counter read zero
        check("R10", NCNT, 0);
        check("R10", (1 << IW) - 1, 0);

        // random run against the model
        rnd = 32'h1d2c_3b4a;
        for (int n = 0; n < 800; n++) begin
            rnd = rnd ^ (rnd << 13);
            rnd = rnd ^ (rnd >> 17);
            rnd = rnd ^ (rnd << 5);
            mon_en  = (rnd[31:29] != 3'b000);
            cnt_clr = (rnd[28:25] == 4'b0000);
            gn = rnd[9] ? '1 : ~(NAG'(1) << rnd[8:7]);
            cyc(rnd[0], rnd[1], rnd[2], rnd[6:3], gn);
            if ((n % 16) == 15) check_all();
        end
        cnt_clr = 1'b0;
        mon_en  = 1'b1;
        check_all();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule